// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a small sectored NOR-style flash array. A host issues byte-wide write cycles, each an address plus a data byte. The block decodes these as one-cycle or two-cycle command sequences. It runs erase and program operations on an internal byte array. It keeps a sticky status byte and refuses operations on sectors that are protected. Reads are combinational, and they return array bytes, the status byte or identification codes depending on the current read mode.

The array has eleven sectors. Sectors 0 to 3 are small sub-sectors at the bottom of the address space, each SUB_BYTES long. Sectors 4 to 10 are main sectors above them, each MAIN_BYTES long. With the defaults the array is 128 bytes. Bytes 0..15 hold sectors 0..3 at four bytes each, and sector k of 4..10 starts at byte 16+16*(k-4). Operation time is modelled with a busy counter: ERASE_CYC cycles for an erase and PROG_CYC cycles for a program.

Top module: `flash_cui`

## Requirements
- R1: After reset every array byte is FFh, reads return array data, and the status byte is 80h. The status layout is: bit 7 ready, bit 5 erase error, bit 4 program error, bit 3 protection error, all other bits 0.
- R2: A single write of FFh selects array reads. A single write of 70h selects status reads. A single write of 90h selects identification reads, where address 0 returns MFR_CODE (A5h), address 1 returns DEV_CODE (3Ch) and any other address returns 00h.
- R3: Programming is a write of 40h or 10h followed by a write of the data byte to the target address. Both opcodes behave the same. The stored byte becomes the old byte AND the new data. Reads return status afterwards.
- R4: Sector erase is 20h to any address in a sector followed by D0h to an address in that same sector. It sets every byte of that sector to FFh and leaves every other sector unchanged.
- R5: A write of 21h then a write of D0h, both to sub-sector addresses, erases sectors 0 to 3 together. It leaves the main sectors unchanged.
- R6: A program or sector erase aimed at a sector whose hw_prot_i or lock_i bit is set does not change the array. It sets the protection error bit together with the program error bit or the erase error bit. A combined sub-sector erase fails in the same way if any of sectors 0 to 3 is protected or locked.
- R7: Error bits are sticky across later commands and are cleared only by a single write of 50h. That write leaves the read mode unchanged.
- R8: After the confirming write, the ready bit reads 0 for exactly ERASE_CYC cycles for an erase and exactly PROG_CYC cycles for a program. While busy, every read returns the status byte whatever the read mode.
- R9: Writes made while busy are ignored, including a write sampled on the very edge at which the operation completes. Such a write changes neither the read mode nor the status.
- R10: A second cycle other than D0h after 20h or 21h sets both the erase and program error bits, leaves the array unchanged and selects array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write cycle strobe, sampled on the rising edge |
| addr_i | input | AW (7) | Byte address for writes and reads |
| wdata_i | input | 8 | Write data / command byte |
| hw_prot_i | input | 11 | Per-sector hardware write protection |
| lock_i | input | 11 | Per-sector write lock |
| rdata_o | output | 8 | Read data for addr_i in the current read mode |

## Verification
The same clock edge can carry both the completion of a busy operation and a new command write. Completion clears the busy state and commits the array update, while the write has to be dropped. The bench provokes this by timing an FFh write so that it is sampled on the completion edge of a program. It then judges the result by reading back: the status byte (80h) must still be returned instead of array data, and a later FFh must then restore array reads showing the programmed byte. A second check places an FFh write in the middle of the busy window and expects the same outcome.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_UERASE     = 8'h21;
  localparam logic [7:0] OP_PROG_A     = 8'h40;
  localparam logic [7:0] OP_PROG_B     = 8'h10;
  localparam logic [7:0] OP_STATUS     = 8'h70;
  localparam logic [7:0] OP_CLEAR      = 8'h50;
  localparam logic [7:0] OP_ID         = 8'h90;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_ID     = 2'd2
  } rmode_e;

  typedef enum logic [2:0] {
    CS_IDLE        = 3'd0,
    CS_ERASE_WAIT  = 3'd1,
    CS_UERASE_WAIT = 3'd2,
    CS_PROG_WAIT   = 3'd3,
    CS_BUSY        = 3'd4
  } cstate_e;

  typedef enum logic [1:0] {
    OPK_ERASE  = 2'd0,
    OPK_UERASE = 2'd1,
    OPK_PROG   = 2'd2
  } opk_e;

  typedef struct packed {
    logic erase_err;
    logic prog_err;
    logic prot_err;
  } err_t;

endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map #(
  parameter int SUB_BYTES  = 4,
  parameter int MAIN_BYTES = 16,
  parameter int N_SUB      = 4,
  parameter int AW         = 7,
  parameter int SW         = 4
) (
  input  logic [AW-1:0] addr_i,
  output logic [SW-1:0] sec_o
);
  localparam int SUB_SPAN = N_SUB * SUB_BYTES;

  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  always_comb begin
    if (a32 < 32'(SUB_SPAN))
      sec_o = SW'(a32 / 32'(SUB_BYTES));
    else
      sec_o = SW'(32'(N_SUB) + (a32 - 32'(SUB_SPAN)) / 32'(MAIN_BYTES));
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= len_i - CW'(1);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = act_q;
  assign done_o = act_q && (cnt_q == '0);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int SUB_BYTES  = 4,
  parameter int MAIN_BYTES = 16,
  parameter int N_SUB      = 4,
  parameter int DEPTH      = 128,
  parameter int AW         = 7,
  parameter int SW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_en_i,
  input  logic [SW-1:0] erase_lo_i,
  input  logic [SW-1:0] erase_hi_i,
  input  logic          prog_en_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [7:0]    prog_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam int SUB_SPAN = N_SUB * SUB_BYTES;

  logic [7:0] bank [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam int SEC = (g < SUB_SPAN) ? (g / SUB_BYTES)
                                        : (N_SUB + (g - SUB_SPAN) / MAIN_BYTES);
    logic [7:0] byte_q;
    logic       hit_erase;
    logic       hit_prog;

    assign hit_erase = erase_en_i && (SW'(SEC) >= erase_lo_i) && (SW'(SEC) <= erase_hi_i);
    assign hit_prog  = prog_en_i && (prog_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        byte_q <= 8'hFF;
      else if (hit_erase) byte_q <= 8'hFF;
      else if (hit_prog)  byte_q <= byte_q & prog_data_i;
    end

    assign bank[g] = byte_q;
  end

  assign rd_data_o = bank[rd_addr_i];
endmodule

// File: rtl/flash_cui.sv
module flash_cui
  import flash_cui_pkg::*;
#(
  parameter int         SUB_BYTES  = 4,
  parameter int         MAIN_BYTES = 16,
  parameter int         N_SUB      = 4,
  parameter int         N_MAIN     = 7,
  parameter int         ERASE_CYC  = 24,
  parameter int         PROG_CYC   = 4,
  parameter logic [7:0] MFR_CODE   = 8'hA5,
  parameter logic [7:0] DEV_CODE   = 8'h3C,
  localparam int        N_SEC      = N_SUB + N_MAIN,
  localparam int        DEPTH      = N_SUB * SUB_BYTES + N_MAIN * MAIN_BYTES,
  localparam int        AW         = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       wdata_i,
  input  logic [N_SEC-1:0] hw_prot_i,
  input  logic [N_SEC-1:0] lock_i,
  output logic [7:0]       rdata_o
);
  localparam int SW     = $clog2(N_SEC);
  localparam int MAXCYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW     = $clog2(MAXCYC + 1);

  cstate_e       state_q, state_n;
  rmode_e        rmode_q, rmode_n;
  err_t          err_q, err_n;
  opk_e          op_q, op_n;
  logic [SW-1:0] tgt_q, tgt_n;
  logic [AW-1:0] pg_addr_q, pg_addr_n;
  logic [7:0]    pg_data_q, pg_data_n;

  logic [SW-1:0]    wr_sec;
  logic [N_SEC-1:0] blocked;
  logic             sub_blocked;
  logic             wr_is_sub, tgt_is_sub;
  logic             t_start, t_busy, t_done;
  logic [CW-1:0]    t_len;
  logic             busy, op_uni;
  logic             erase_en, prog_en;
  logic [SW-1:0]    erase_lo, erase_hi;
  logic [7:0]       arr_data, status_byte, id_byte;

  flash_sector_map #(
    .SUB_BYTES (SUB_BYTES),
    .MAIN_BYTES(MAIN_BYTES),
    .N_SUB     (N_SUB),
    .AW        (AW),
    .SW        (SW)
  ) u_map (
    .addr_i(addr_i),
    .sec_o (wr_sec)
  );

  assign blocked     = hw_prot_i | lock_i;
  assign sub_blocked = |blocked[N_SUB-1:0];
  assign wr_is_sub   = wr_sec < SW'(N_SUB);
  assign tgt_is_sub  = tgt_q < SW'(N_SUB);

  always_comb begin
    state_n   = state_q;
    rmode_n   = rmode_q;
    err_n     = err_q;
    op_n      = op_q;
    tgt_n     = tgt_q;
    pg_addr_n = pg_addr_q;
    pg_data_n = pg_data_q;
    t_start   = 1'b0;
    t_len     = CW'(PROG_CYC);

    unique case (state_q)
      CS_IDLE: begin
        if (wr_en_i) begin
          case (wdata_i)
            OP_READ_ARRAY: rmode_n = RM_ARRAY;
            OP_STATUS:     rmode_n = RM_STATUS;
            OP_ID:         rmode_n = RM_ID;
            OP_CLEAR:      err_n   = '0;
            OP_ERASE: begin
              state_n = CS_ERASE_WAIT;
              tgt_n   = wr_sec;
              rmode_n = RM_STATUS;
            end
            OP_UERASE: begin
              state_n = CS_UERASE_WAIT;
              tgt_n   = wr_sec;
              rmode_n = RM_STATUS;
            end
            OP_PROG_A, OP_PROG_B: begin
              state_n = CS_PROG_WAIT;
              rmode_n = RM_STATUS;
            end
            default: ;
          endcase
        end
      end

      CS_ERASE_WAIT: begin
        if (wr_en_i) begin
          state_n = CS_IDLE;
          if (wdata_i == OP_CONFIRM && wr_sec == tgt_q) begin
            if (blocked[wr_sec]) begin
              err_n.erase_err = 1'b1;
              err_n.prot_err  = 1'b1;
            end else begin
              state_n = CS_BUSY;
              op_n    = OPK_ERASE;
              t_start = 1'b1;
              t_len   = CW'(ERASE_CYC);
            end
          end else begin
            err_n.erase_err = 1'b1;
            err_n.prog_err  = 1'b1;
            rmode_n         = RM_ARRAY;
          end
        end
      end

      CS_UERASE_WAIT: begin
        if (wr_en_i) begin
          state_n = CS_IDLE;
          if (wdata_i == OP_CONFIRM && wr_is_sub && tgt_is_sub) begin
            if (sub_blocked) begin
              err_n.erase_err = 1'b1;
              err_n.prot_err  = 1'b1;
            end else begin
              state_n = CS_BUSY;
              op_n    = OPK_UERASE;
              t_start = 1'b1;
              t_len   = CW'(ERASE_CYC);
            end
          end else begin
            err_n.erase_err = 1'b1;
            err_n.prog_err  = 1'b1;
            rmode_n         = RM_ARRAY;
          end
        end
      end

      CS_PROG_WAIT: begin
        if (wr_en_i) begin
          if (blocked[wr_sec]) begin
            state_n        = CS_IDLE;
            err_n.prog_err = 1'b1;
            err_n.prot_err = 1'b1;
          end else begin
            state_n   = CS_BUSY;
            op_n      = OPK_PROG;
            pg_addr_n = addr_i;
            pg_data_n = wdata_i;
            t_start   = 1'b1;
            t_len     = CW'(PROG_CYC);
          end
        end
      end

      CS_BUSY: begin
        rmode_n = RM_STATUS;
        if (t_done) state_n = CS_IDLE;
      end

      default: state_n = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CS_IDLE;
      rmode_q   <= RM_ARRAY;
      err_q     <= '0;
      op_q      <= OPK_ERASE;
      tgt_q     <= '0;
      pg_addr_q <= '0;
      pg_data_q <= 8'hFF;
    end else begin
      state_q   <= state_n;
      rmode_q   <= rmode_n;
      err_q     <= err_n;
      op_q      <= op_n;
      tgt_q     <= tgt_n;
      pg_addr_q <= pg_addr_n;
      pg_data_q <= pg_data_n;
    end
  end

  flash_busy_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(t_start),
    .len_i  (t_len),
    .busy_o (t_busy),
    .done_o (t_done)
  );

  assign busy     = (state_q == CS_BUSY);
  assign op_uni   = (op_q == OPK_UERASE);
  assign erase_en = busy && t_done && (op_q != OPK_PROG);
  assign prog_en  = busy && t_done && (op_q == OPK_PROG);
  assign erase_lo = op_uni ? '0 : tgt_q;
  assign erase_hi = op_uni ? SW'(N_SUB - 1) : tgt_q;

  flash_array #(
    .SUB_BYTES (SUB_BYTES),
    .MAIN_BYTES(MAIN_BYTES),
    .N_SUB     (N_SUB),
    .DEPTH     (DEPTH),
    .AW        (AW),
    .SW        (SW)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .erase_en_i (erase_en),
    .erase_lo_i (erase_lo),
    .erase_hi_i (erase_hi),
    .prog_en_i  (prog_en),
    .prog_addr_i(pg_addr_q),
    .prog_data_i(pg_data_q),
    .rd_addr_i  (addr_i),
    .rd_data_o  (arr_data)
  );

  assign status_byte = {~t_busy, 1'b0, err_q.erase_err, err_q.prog_err, err_q.prot_err, 3'b000};

  always_comb begin
    if (addr_i == AW'(0))      id_byte = MFR_CODE;
    else if (addr_i == AW'(1)) id_byte = DEV_CODE;
    else                       id_byte = 8'h00;
  end

  always_comb begin
    if (busy) rdata_o = status_byte;
    else begin
      case (rmode_q)
        RM_ARRAY:  rdata_o = arr_data;
        RM_ID:     rdata_o = id_byte;
        default:   rdata_o = status_byte;
      endcase
    end
  end

endmodule

// File: rtl/flash_cui_chk.sv
module flash_cui_chk #(
  parameter int N_SEC = 11,
  parameter int N_SUB = 4,
  parameter int SW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [7:0]       wdata_i,
  input logic [N_SEC-1:0] blk_i,
  input logic [SW-1:0]    wr_sec,
  input logic             busy,
  input logic             done,
  input logic             uni,
  input logic [2:0]       err,
  input logic [7:0]       rdata_o
);

  // R8: while busy the ready bit seen by readers is low
  a_r8_busy_reads_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (rdata_o[7] == 1'b0));

  // R9: writes during busy cannot disturb the error bits
  a_r9_busy_err_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> $stable(err));

  // R6: an operation started on a single sector had it unprotected
  a_r6_start_unblocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && !uni) |-> !$past(blk_i[wr_sec]));

  // R5: combined erase starts only with all sub-sectors unprotected
  a_r5_uni_unblocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy) && uni) |-> !$past(|blk_i[N_SUB-1:0]));

  // R7: an error bit falls only after an accepted clear command
  a_r7_clear_only_by_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(err) & ~err)) |-> $past(wr_en_i && (wdata_i == 8'h50) && !busy));

endmodule

bind flash_cui flash_cui_chk #(
  .N_SEC(N_SEC),
  .N_SUB(N_SUB),
  .SW   (SW)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .wdata_i(wdata_i),
  .blk_i  (hw_prot_i | lock_i),
  .wr_sec (wr_sec),
  .busy   (busy),
  .done   (t_done),
  .uni    (op_uni),
  .err    (err_q),
  .rdata_o(rdata_o)
);

// File: tb/flash_cui_test.sv
`timescale 1ns/1ps
module flash_cui_test;
  localparam int ERASE_CYC = 24;
  localparam int PROG_CYC  = 4;
  localparam int AW        = 7;
  localparam int N_SEC     = 11;

  typedef struct {
    logic [AW-1:0] addr;
    logic [7:0]    exp;
    string         tag;
  } item_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic [7:0]       wdata_i = '0;
  logic [N_SEC-1:0] hw_prot_i = '0;
  logic [N_SEC-1:0] lock_i = '0;
  logic [7:0]       rdata_o;

  int checks = 0;
  int errors = 0;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  flash_cui #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .hw_prot_i(hw_prot_i),
    .lock_i   (lock_i),
    .rdata_o  (rdata_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(rdata_o == it.exp, it.tag, rdata_o, it.exp);
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(posedge clk_i); #1;
    addr_i = AW'(a); wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk_i); #1;
    addr_i = AW'(a);
    it.addr = AW'(a); it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i); #1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i);
      if (rdata_o[7]) break;
      n++;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(0, 8'hFF, "R1 reset array byte 0");
    rd(127, 8'hFF, "R1 reset array byte 127");
    wr(0, 8'h70);
    rd(0, 8'h80, "R1 reset status");

    // R2 read modes
    wr(0, 8'h90);
    rd(0, 8'hA5, "R2 id manufacturer");
    rd(1, 8'h3C, "R2 id device");
    rd(2, 8'h00, "R2 id other");
    wr(0, 8'hFF);
    rd(5, 8'hFF, "R2 back to array");

    // R3 program with both opcodes, AND behaviour, R8 program busy length
    wr(20, 8'h40); wr(20, 8'h5A);
    wait_ready(n);
    check(n == PROG_CYC, "R8 program busy cycles", n, PROG_CYC);
    rd(0, 8'h80, "R3 status after program");
    wr(0, 8'hFF);
    rd(20, 8'h5A, "R3 programmed byte");
    wr(20, 8'h10); wr(20, 8'h0F);
    wait_ready(n);
    wr(0, 8'hFF);
    rd(20, 8'h0A, "R3 second opcode AND");

    // fill some sectors
    wr(3, 8'h40);   wr(3, 8'h12);   wait_ready(n);
    wr(9, 8'h40);   wr(9, 8'h34);   wait_ready(n);
    wr(40, 8'h40);  wr(40, 8'h77);  wait_ready(n);
    wr(127, 8'h10); wr(127, 8'h00); wait_ready(n);

    // R4 sector erase of sector 5 (bytes 32..47)
    wr(32, 8'h20); wr(47, 8'hD0);
    wait_ready(n);
    check(n == ERASE_CYC, "R8 erase busy cycles", n, ERASE_CYC);
    wr(0, 8'hFF);
    rd(40, 8'hFF, "R4 erased byte");
    rd(20, 8'h0A, "R4 neighbour sector kept");
    rd(127, 8'h00, "R4 far sector kept");

    // R10 bad confirm byte
    wr(20, 8'h20); wr(20, 8'h55);
    rd(20, 8'h0A, "R10 array mode and array kept");
    wr(0, 8'h70);
    rd(0, 8'hB0, "R10 both error bits");
    wr(0, 8'h50);
    rd(0, 8'h80, "R7 clear keeps status mode");

    // R6 locked sector 4
    lock_i[4] = 1'b1;
    wr(20, 8'h40); wr(20, 8'h00);
    rd(0, 8'h98, "R6 program blocked status");
    wr(0, 8'hFF);
    rd(20, 8'h0A, "R6 program blocked array");
    wr(16, 8'h20); wr(16, 8'hD0);
    rd(0, 8'hB8, "R7 sticky program error plus erase error");
    wr(0, 8'hFF);
    rd(16, 8'hFF, "R6 erase blocked array");
    rd(20, 8'h0A, "R6 erase blocked array byte 20");
    wr(0, 8'h50);
    wr(0, 8'h70);
    rd(0, 8'h80, "R7 cleared");
    lock_i[4] = 1'b0;

    // R5 combined erase blocked by sub-sector 2 protection
    hw_prot_i[2] = 1'b1;
    wr(1, 8'h21); wr(1, 8'hD0);
    rd(0, 8'hA8, "R6 combined erase blocked status");
    wr(0, 8'hFF);
    rd(3, 8'h12, "R5 blocked keeps sector 0");
    rd(9, 8'h34, "R5 blocked keeps sector 2");
    wr(0, 8'h50);
    hw_prot_i[2] = 1'b0;

    // R5 combined erase
    wr(5, 8'h21); wr(5, 8'hD0);
    wait_ready(n);
    check(n == ERASE_CYC, "R5 combined erase busy cycles", n, ERASE_CYC);
    wr(0, 8'hFF);
    rd(3, 8'hFF, "R5 sector 0 erased");
    rd(9, 8'hFF, "R5 sector 2 erased");
    rd(20, 8'h0A, "R5 main sector kept");
    rd(127, 8'h00, "R5 top sector kept");

    // R8/R9 mid-busy read and write
    wr(0, 8'hFF);
    wr(60, 8'h40); wr(60, 8'h11);
    rd(60, 8'h00, "R8 status while busy");
    wr(0, 8'hFF);
    wait_ready(n);
    rd(60, 8'h80, "R9 mid-busy write ignored");

    // R9 write on the completion edge
    wr(100, 8'h40); wr(100, 8'hF0);
    repeat (PROG_CYC - 2) @(posedge clk_i);
    wr(0, 8'hFF);
    rd(100, 8'h80, "R9 completion-edge write ignored");
    wr(0, 8'hFF);
    rd(100, 8'hF0, "R9 program committed");
    rd(60, 8'h11, "R3 mid-busy program committed");

    repeat (2) @(posedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule